// File: doc/BRIEF.md
# Critical-Conduction Gate Pulse Timer

This block produces the power-switch gate pulse for a variable-frequency converter that runs at the boundary between continuous and discontinuous conduction. A counter that starts from zero at each turn-on stands in for an analog ramp. The on-time ends when that counter reaches the commanded on-time, or earlier when a cycle-by-cycle overcurrent input asserts after a blanking window. The block then waits for the zero-current detector to fall and counts a programmable valley delay. After that delay it starts the next cycle.

The period is bounded on both sides, and both limits are measured from the previous turn-on. A floor on the period acts as the maximum-frequency clamp. A ceiling forces a restart when no zero-current event arrives, and acts as the minimum-frequency clamp. The on-time is never shorter than a minimum floor. After reset, a soft-start limit grows slowly from zero and caps the commanded on-time. An external dimming PWM drives the gate-enable input to block the drive. An undervoltage flag blocks it the same way. All times are counted in cycles of one system clock. The on-time and delay commands are registered before use.

Top module: `crcm_gate_timer`

## Requirements
- R1: `gate_out` is 0 while `rst_n` is low or `uv_flag` is high, in the same cycle, and the first turn-on after the blocking condition clears occurs at the next rising clock edge.
- R2: While `gate_en` is low, `gate_out` is 0 in the same cycle, even in the middle of a pulse, and no new pulse starts. When `gate_en` returns high, the gate turns on at the next rising edge.
- R3: With no overcurrent, the gate stays high for exactly max(MIN_ON_CYC, min(ton_cmd, soft-start limit)) clock cycles. A command below MIN_ON_CYC gives MIN_ON_CYC cycles.
- R4: The on-time counter restarts from zero at every turn-on and is zero after every turn-off, so consecutive pulses with the same command have identical widths.
- R5: `oc_in` high ends the pulse at the next edge once LEB_CYC cycles have passed since turn-on. A pulse with `oc_in` high from turn-on lasts LEB_CYC+1 cycles. `oc_in` has no effect while the gate is low.
- R6: A falling edge on `zcd_in` seen while the gate is low, after the pulse, starts the valley delay. If `zcd_in` is changed just after rising edge number z after turn-on (z ≥ on-time), the next turn-on comes z+3+max(dly_cmd,1) cycles after the previous turn-on. This holds unless a clamp applies.
- R7: The period between two turn-ons is never shorter than MIN_PER_CYC cycles. A restart that would come earlier is held until exactly MIN_PER_CYC.
- R8: If no zero-current delay completes first, a new turn-on is forced exactly MAX_PER_CYC cycles after the previous one.
- R9: After reset, the soft-start limit starts at 0 and grows by one every SS_DIV_CYC cycles up to the counter maximum. The first pulse after reset lasts MIN_ON_CYC cycles, and pulses widen gradually until the command is reached.
- R10: Edges on `zcd_in` while the gate is high have no effect on the current pulse or on the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all times counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag | input | 1 | Undervoltage flag; blocks the drive while high |
| gate_en | input | 1 | Dimming enable; low blocks the drive |
| ton_cmd | input | CNT_W | Commanded on-time in cycles |
| dly_cmd | input | CNT_W | Valley delay after zero-current detection, in cycles |
| zcd_in | input | 1 | Asynchronous zero-current detect; acts on its falling edge |
| oc_in | input | 1 | Cycle-by-cycle overcurrent input |
| gate_out | output | 1 | Power-switch gate drive |

## Verification
A corrupted on-time counter shows up as a wrong pulse width on `gate_out` within the same pulse. A stale or uncleared counter also makes two identical commands give different widths. A broken period counter or a wrong state in the off phase shows up as a turn-on that is early, late or missing. It becomes visible at the next rising edge of `gate_out`, at most MAX_PER_CYC cycles later. A soft-start limit that does not start at zero shows in the first pulse after reset.

// File: rtl/crcm_pkg.sv
package crcm_pkg;

    typedef enum logic [2:0] {
        ST_PARK,
        ST_ON,
        ST_WAIT,
        ST_DELAY,
        ST_HOLD
    } crcm_state_e;

endpackage

// File: rtl/crcm_edge_sync.sv
module crcm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    // bit 0 is the first flop; bit STAGES holds the previous synchronised value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R6

endmodule

// File: rtl/crcm_softstart.sv
module crcm_softstart #(
    parameter int W       = 16,
    parameter int DIV_CYC = 610
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] lim
);
    localparam int DW = (DIV_CYC > 1) ? $clog2(DIV_CYC) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV_CYC - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [W-1:0]  lim;
    } ss_t;

    ss_t ss_d, ss_q;

    always_comb begin
        ss_d = ss_q;
        if (ss_q.div == DIV_LAST) begin
            ss_d.div = '0;
            if (ss_q.lim != '1) ss_d.lim = ss_q.lim + W'(1);
        end else begin
            ss_d.div = ss_q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ss_q <= '0;
        else        ss_q <= ss_d;
    end

    assign lim = ss_q.lim;

    AST_SS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ss_q.lim >= $past(ss_q.lim))); // R9

endmodule

// File: rtl/crcm_ontime_sel.sv
module crcm_ontime_sel #(
    parameter int W          = 16,
    parameter int MIN_ON_CYC = 20
) (
    input  logic [W-1:0] cmd,
    input  logic [W-1:0] lim,
    output logic [W-1:0] target
);
    localparam logic [W-1:0] MIN_V = W'(MIN_ON_CYC);

    logic [W-1:0] capped;

    always_comb begin
        capped = (cmd < lim) ? cmd : lim;
        target = (capped < MIN_V) ? MIN_V : capped;
    end

endmodule

// File: rtl/crcm_gate_timer.sv
module crcm_gate_timer
    import crcm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int LEB_CYC     = 12,
    parameter int MIN_ON_CYC  = 20,
    parameter int MIN_PER_CYC = 100,
    parameter int MAX_PER_CYC = 4000,
    parameter int SS_DIV_CYC  = 610
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uv_flag,
    input  logic             gate_en,
    input  logic [CNT_W-1:0] ton_cmd,
    input  logic [CNT_W-1:0] dly_cmd,
    input  logic             zcd_in,
    input  logic             oc_in,
    output logic             gate_out
);
    localparam int PW = $clog2(MAX_PER_CYC + 1);
    localparam logic [CNT_W:0] LEB_V    = (CNT_W+1)'(LEB_CYC);
    localparam logic [PW:0]    MINP_V   = (PW+1)'(MIN_PER_CYC);
    localparam logic [PW:0]    MAXP_V   = (PW+1)'(MAX_PER_CYC);

    typedef struct packed {
        crcm_state_e      state;
        logic             gate;
        logic [CNT_W-1:0] ramp;
        logic [CNT_W-1:0] dcnt;
        logic [PW-1:0]    per;
        logic [CNT_W-1:0] ton;
        logic [CNT_W-1:0] dly;
    } core_t;

    core_t c_d, c_q;

    logic             zcd_fall;
    logic [CNT_W-1:0] ss_lim;
    logic [CNT_W-1:0] on_target;
    logic             en_ok;
    logic [CNT_W:0]   ramp_nx;
    logic [CNT_W:0]   dcnt_nx;
    logic [PW:0]      per_nx;
    logic             floor_met;
    logic             ceil_hit;

    crcm_edge_sync #(.STAGES(2)) i_zcd_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (zcd_in),
        .fall (zcd_fall)
    );

    crcm_softstart #(.W(CNT_W), .DIV_CYC(SS_DIV_CYC)) i_softstart (
        .clk  (clk),
        .rst_n(rst_n),
        .lim  (ss_lim)
    );

    crcm_ontime_sel #(.W(CNT_W), .MIN_ON_CYC(MIN_ON_CYC)) i_ontime_sel (
        .cmd   (c_q.ton),
        .lim   (ss_lim),
        .target(on_target)
    );

    assign en_ok     = gate_en & ~uv_flag;
    assign ramp_nx   = {1'b0, c_q.ramp} + (CNT_W+1)'(1);
    assign dcnt_nx   = {1'b0, c_q.dcnt} + (CNT_W+1)'(1);
    assign per_nx    = {1'b0, c_q.per} + (PW+1)'(1);
    assign floor_met = (per_nx >= MINP_V);
    assign ceil_hit  = (per_nx >= MAXP_V);

    always_comb begin
        c_d     = c_q;
        c_d.ton = ton_cmd;
        c_d.dly = dly_cmd;
        if (c_q.per != '1) c_d.per = c_q.per + PW'(1);

        if (!en_ok) begin
            c_d.state = ST_PARK;
            c_d.gate  = 1'b0;
            c_d.ramp  = '0;
        end else begin
            unique case (c_q.state)
                ST_PARK: begin
                    c_d.state = ST_ON;
                    c_d.gate  = 1'b1;
                    c_d.ramp  = '0;
                    c_d.per   = '0;
                end
                ST_ON: begin
                    if ((ramp_nx >= {1'b0, on_target}) ||
                        (oc_in && ({1'b0, c_q.ramp} >= LEB_V))) begin
                        c_d.state = ST_WAIT;
                        c_d.gate  = 1'b0;
                        c_d.ramp  = '0;
                    end else begin
                        c_d.ramp  = ramp_nx[CNT_W-1:0];
                    end
                end
                ST_WAIT: begin
                    if (ceil_hit) begin
                        c_d.state = ST_ON;
                        c_d.gate  = 1'b1;
                        c_d.per   = '0;
                    end else if (zcd_fall) begin
                        c_d.state = ST_DELAY;
                        c_d.dcnt  = '0;
                    end
                end
                ST_DELAY: begin
                    if (ceil_hit || ((dcnt_nx >= {1'b0, c_q.dly}) && floor_met)) begin
                        c_d.state = ST_ON;
                        c_d.gate  = 1'b1;
                        c_d.per   = '0;
                    end else if (dcnt_nx >= {1'b0, c_q.dly}) begin
                        c_d.state = ST_HOLD;
                    end else begin
                        c_d.dcnt  = dcnt_nx[CNT_W-1:0];
                    end
                end
                ST_HOLD: begin
                    if (floor_met) begin
                        c_d.state = ST_ON;
                        c_d.gate  = 1'b1;
                        c_d.per   = '0;
                    end
                end
                default: begin
                    c_d.state = ST_PARK;
                    c_d.gate  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_PARK;
        end else begin
            c_q       <= c_d;
        end
    end

    assign gate_out = c_q.gate & en_ok & rst_n;

    AST_PARK_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ok |=> (c_q.state == ST_PARK) && !c_q.gate); // R2

    AST_FLOOR_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(c_q.gate) && ($past(c_q.state) != ST_PARK))
        |-> (int'($past(c_q.per)) + 1 >= MIN_PER_CYC)); // R7

    AST_CEIL_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (((c_q.state == ST_WAIT) || (c_q.state == ST_DELAY)) &&
         (($past(c_q.state) == ST_WAIT) || ($past(c_q.state) == ST_DELAY)))
        |-> (int'(c_q.per) < MAX_PER_CYC)); // R8

    AST_RAMP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.gate) |-> (c_q.ramp == '0)); // R4

    AST_SHORT_ONLY_BY_OC: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(c_q.gate) && ($past(c_q.state) == ST_ON) && $past(en_ok))
        |-> ((int'($past(c_q.ramp)) + 1 >= MIN_ON_CYC) ||
             ($past(oc_in) && (int'($past(c_q.ramp)) >= LEB_CYC)))); // R5

endmodule

// File: tb/test_crcm_gate_timer.sv
module test_crcm_gate_timer;
    localparam int W      = 12;
    localparam int LEB    = 12;
    localparam int MINON  = 20;
    localparam int MINPER = 100;
    localparam int MAXPER = 4000;
    localparam int SSDIV  = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         uv = 1'b0;
    logic         en = 1'b1;
    logic         zcd = 1'b0;
    logic         oc = 1'b0;
    logic [W-1:0] ton = W'(1000);
    logic [W-1:0] dly = W'(10);
    logic         gate;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    crcm_gate_timer #(
        .CNT_W(W), .LEB_CYC(LEB), .MIN_ON_CYC(MINON),
        .MIN_PER_CYC(MINPER), .MAX_PER_CYC(MAXPER), .SS_DIV_CYC(SSDIV)
    ) i_crcm_gate_timer (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv), .gate_en(en),
        .ton_cmd(ton), .dly_cmd(dly), .zcd_in(zcd), .oc_in(oc),
        .gate_out(gate)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int expv);
        checks = checks + 1;
        if (act != expv) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int f_on(input int t, input bit ocm);
        int v;
        v = (t < MINON) ? MINON : t;
        if (ocm && v > LEB + 1) v = LEB + 1;
        return v;
    endfunction

    function automatic int f_per(input int z, input int d);
        int p;
        if (z < 0) return MAXPER;
        p = z + 3 + ((d < 1) ? 1 : d);
        if (p > MAXPER) p = MAXPER;
        if (p < MINPER) p = MINPER;
        return p;
    endfunction

    // zero-current follows the gate so the converter restarts quickly
    task automatic wait_rise();
        int n = 0;
        while (gate && n < 10000) begin tick(); zcd = gate; n++; end
        while (!gate && n < 20000) begin tick(); zcd = gate; n++; end
    endtask

    // om: 0 plain, 1 overcurrent from turn-on, 2 overcurrent while off, 3 zcd glitch while on
    task automatic measure(input int t, input int d, input int z, input int om,
                           input string on_tag, input string per_tag);
        int k = 0;
        int w = -1;
        int p = -1;
        int ep;
        ton = W'(t);
        dly = W'(d);
        wait_rise();
        zcd = 1'b1;
        oc  = (om == 1);
        while (p < 0 && k < 10000) begin
            tick();
            k++;
            if (om == 3 && k == 2) zcd = 1'b0;
            if (om == 3 && k == 6) zcd = 1'b1;
            if (k == z) zcd = 1'b0;
            if (w < 0 && !gate) begin
                w  = k;
                oc = (om == 2);
            end else if (w >= 0 && gate) begin
                p = k;
            end
        end
        oc = 1'b0;
        ep = f_per(z, d);
        chk(on_tag, w, f_on(t, om == 1));
        chk(per_tag, p, ep);
    endtask

    initial begin
        int w;
        int highs;
        void'($urandom(7321));

        // reset holds the gate low
        repeat (3) tick();
        chk("R1", int'(gate), 0);
        rst_n = 1'b1;

        // first pulse after reset is at the minimum on-time
        wait_rise();
        w = 0;
        while (gate && w < 5000) begin tick(); w++; end
        chk("R9", w, MINON);

        // mid soft-start: wider than the floor, narrower than the command
        while (cyc < 2000) begin tick(); zcd = gate; end
        wait_rise();
        w = 0;
        while (gate && w < 5000) begin tick(); w++; end
        chk("R9", int'(w > MINON && w < 1000), 1);

        while (cyc < 17500) begin tick(); zcd = gate; end
        measure(1000, 10, 1010, 0, "R9", "R6");

        // directed corner cases
        measure(10, 5, 40, 0, "R3", "R7");
        measure(200, 50, 210, 0, "R3", "R6");
        measure(200, 50, 210, 0, "R4", "R4");
        measure(200, 50, -1, 0, "R3", "R8");
        measure(100, 20, 120, 3, "R10", "R10");
        measure(150, 30, 160, 1, "R5", "R5");
        measure(150, 30, 160, 2, "R5", "R5");
        measure(60, 1, 60, 0, "R3", "R7");

        // gate enable blocks mid-pulse and releases on the next edge
        wait_rise();
        tick(); tick();
        en = 1'b0;
        #1;
        chk("R2", int'(gate), 0);
        highs = 0;
        for (int i = 0; i < 50; i++) begin tick(); zcd = 1'b0; if (gate) highs++; end
        chk("R2", highs, 0);
        en = 1'b1;
        tick();
        chk("R2", int'(gate), 1);

        // undervoltage behaves the same way
        tick();
        uv = 1'b1;
        #1;
        chk("R1", int'(gate), 0);
        highs = 0;
        for (int i = 0; i < 30; i++) begin tick(); if (gate) highs++; end
        chk("R1", highs, 0);
        uv = 1'b0;
        tick();
        chk("R1", int'(gate), 1);

        // constrained random cycles
        for (int i = 0; i < 24; i++) begin
            int t  = 5 + int'($urandom % 300);
            int d  = 1 + int'($urandom % 200);
            int om = int'($urandom % 3);
            int z  = f_on(t, om == 1) + int'($urandom % 80);
            int ep = f_per(z, d);
            string pt;
            pt = (ep == MINPER) ? "R7" : ((ep == MAXPER) ? "R8" : "R6");
            measure(t, d, z, om, (om == 0) ? "R3" : "R5", pt);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule